// File: doc/BRIEF.md
# Settling Delay and Ready Flag Timer

This block drives a channels-ready status flag for an acquisition front end. Whenever a critical acquisition parameter changes, the flag goes low for a settling interval. The flag returns high once that interval has run out. Five causes can start an interval, each with its own length: a full initialization, an input buffer reset, a change of sample rate, a converter synchronization, and the start of a synchronous scan. The buffer-reset interval is longer while synchronous-scan mode is active.

Each cause arrives as a one-cycle strobe. A single down-counter holds the number of cycles that remain low. When a strobe arrives, the counter takes the larger of its decremented value and the new interval, so a later event can extend the low period but can never cut it short. When the counter reaches zero, the flag rises. On that same cycle the block emits a one-cycle ready-rise pulse for the interrupt logic.

All interval lengths are parameters given in clock cycles. This lets the block be scaled for simulation. The reset input is asynchronous and active-low, and it is expected to be released in step with the clock by the reset tree.

Top module: `settle_ready_timer`

## Requirements
- R1: While reset is asserted, `ready` and `ready_rise` are 0. After release, the timer starts with `INIT_CYC` cycles loaded. `ready` goes high on the `INIT_CYC`-th rising edge after release, provided no event arrives.
- R2: If `init_ev` is sampled high at edge E0 and no longer event follows, `ready` is 0 from E0 through E0+`INIT_CYC`-1 and is 1 at E0+`INIT_CYC`.
- R3: When `sync_scan_mode` is 0 at the sampling edge, `bufrst_ev` holds `ready` low for `BRST_FAST_CYC` edges, with the same timing as R2.
- R4: When `sync_scan_mode` is 1 at the sampling edge, `bufrst_ev` holds `ready` low for `BRST_SCAN_CYC` edges.
- R5: `rate_ev` holds `ready` low for `RATE_CYC` edges.
- R6: `sync_ev` holds `ready` low for `SYNC_CYC` edges.
- R7: `scan_ev` holds `ready` low for `SCAN_CYC` edges.
- R8: An event that arrives while `ready` is low sets the remaining low time to the larger of what was left and the new interval. A shorter event never shortens the low period.
- R9: Strobes that are sampled at the same edge act as one event whose interval is the longest among them.
- R10: `ready_rise` is high for exactly the one cycle in which `ready` goes from 0 to 1, and it is low at all other times.
- R11: An event sampled at the edge where the count would reach zero keeps `ready` low, and no `ready_rise` pulse is produced at that edge.
- R12: While `ready` is high and no strobe is present, `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_ev | input | 1 | One-cycle strobe: initialization |
| bufrst_ev | input | 1 | One-cycle strobe: input buffer reset |
| rate_ev | input | 1 | One-cycle strobe: sample rate, divisor or rate assignment change |
| sync_ev | input | 1 | One-cycle strobe: converter synchronization |
| scan_ev | input | 1 | One-cycle strobe: synchronous scan start |
| sync_scan_mode | input | 1 | 1 selects the long buffer-reset interval |
| ready | output | 1 | Channels-ready flag, low while settling |
| ready_rise | output | 1 | One-cycle pulse when `ready` rises |

## Verification
Two functions can fall in the same cycle: the count expiring, and a new event arriving. The bench provokes this by issuing a strobe on exactly the edge where a running interval would end. It then judges that `ready` stays low and that no rise pulse appears at that edge, and that the rise comes only after the new interval has run out. It also fires several strobes together, and fires shorter strobes in the middle of a longer interval, to show that the longest remaining time always wins.

// File: rtl/settle_pkg.sv
package settle_pkg;

  typedef struct packed {
    logic scan;
    logic sync;
    logic rate;
    logic bufrst;
    logic init;
  } settle_ev_t;

  localparam int unsigned NUM_CAUSES = 5;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/settle_interval_sel.sv
module settle_interval_sel
  import settle_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned INIT_CYC      = 20,
  parameter int unsigned BRST_FAST_CYC = 3,
  parameter int unsigned BRST_SCAN_CYC = 12,
  parameter int unsigned RATE_CYC      = 40,
  parameter int unsigned SYNC_CYC      = 15,
  parameter int unsigned SCAN_CYC      = 25
) (
  input  settle_ev_t       ev,
  input  logic             sync_scan_mode,
  output logic [CNT_W-1:0] req
);

  logic [NUM_CAUSES-1:0] hit;
  logic [CNT_W-1:0]      dur [NUM_CAUSES];

  assign hit = ev;

  always_comb begin
    dur[0] = CNT_W'(INIT_CYC);
    dur[1] = sync_scan_mode ? CNT_W'(BRST_SCAN_CYC) : CNT_W'(BRST_FAST_CYC);
    dur[2] = CNT_W'(RATE_CYC);
    dur[3] = CNT_W'(SYNC_CYC);
    dur[4] = CNT_W'(SCAN_CYC);
  end

  always_comb begin
    req = '0;
    for (int i = 0; i < NUM_CAUSES; i++) begin
      if (hit[i] && (dur[i] > req)) req = dur[i];
    end
  end

endmodule

// File: rtl/settle_countdown.sv
module settle_countdown #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned INIT_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] req,
  output logic             zero_next
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] dec;
  logic             cnt_en;

  always_comb begin
    dec       = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    cnt_d     = (req > dec) ? req : dec;
    cnt_en    = (cnt_q != '0) || (req != '0);
    zero_next = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(INIT_CYC);
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/settle_flag_reg.sv
module settle_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_next,
  output logic ready,
  output logic ready_rise
);

  logic ready_d;
  logic rise_d;

  always_comb begin
    ready_d = zero_next;
    rise_d  = zero_next && !ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready      <= 1'b0;
      ready_rise <= 1'b0;
    end else begin
      ready      <= ready_d;
      ready_rise <= rise_d;
    end
  end

endmodule

// File: rtl/settle_ready_timer.sv
module settle_ready_timer
  import settle_pkg::*;
#(
  parameter int unsigned INIT_CYC      = 250000000,
  parameter int unsigned BRST_FAST_CYC = 50,
  parameter int unsigned BRST_SCAN_CYC = 250000,
  parameter int unsigned RATE_CYC      = 5000000,
  parameter int unsigned SYNC_CYC      = 5000000,
  parameter int unsigned SCAN_CYC      = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_ev,
  input  logic bufrst_ev,
  input  logic rate_ev,
  input  logic sync_ev,
  input  logic scan_ev,
  input  logic sync_scan_mode,
  output logic ready,
  output logic ready_rise
);

  localparam int unsigned MAX_CYC = umax(umax(umax(INIT_CYC, BRST_FAST_CYC), umax(BRST_SCAN_CYC, RATE_CYC)),
                                         umax(SYNC_CYC, SCAN_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  settle_ev_t       ev;
  logic [CNT_W-1:0] req;
  logic             zero_next;

  assign ev = '{scan: scan_ev, sync: sync_ev, rate: rate_ev, bufrst: bufrst_ev, init: init_ev};

  settle_interval_sel #(
    .CNT_W(CNT_W), .INIT_CYC(INIT_CYC), .BRST_FAST_CYC(BRST_FAST_CYC),
    .BRST_SCAN_CYC(BRST_SCAN_CYC), .RATE_CYC(RATE_CYC), .SYNC_CYC(SYNC_CYC),
    .SCAN_CYC(SCAN_CYC)
  ) u_sel (
    .ev(ev), .sync_scan_mode(sync_scan_mode), .req(req)
  );

  settle_countdown #(.CNT_W(CNT_W), .INIT_CYC(INIT_CYC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .req(req), .zero_next(zero_next)
  );

  settle_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .zero_next(zero_next),
    .ready(ready), .ready_rise(ready_rise)
  );

endmodule

// File: rtl/settle_ready_chk.sv
module settle_ready_chk (
  input logic clk,
  input logic rst_n,
  input logic init_ev,
  input logic bufrst_ev,
  input logic rate_ev,
  input logic sync_ev,
  input logic scan_ev,
  input logic ready,
  input logic ready_rise
);

  logic any_ev;
  assign any_ev = init_ev | bufrst_ev | rate_ev | sync_ev | scan_ev;

  assert_init_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_ev |=> !ready);
  assert_bufrst_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bufrst_ev |=> !ready);
  assert_rate_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ev |=> !ready);
  assert_sync_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ev |=> !ready);
  assert_scan_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_ev |=> !ready);
  assert_rise_needs_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_rise |-> (ready && !$past(ready)));
  assert_edge_gives_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ready_rise);
  assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_rise |=> !ready_rise);
  assert_collision_no_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && any_ev) |=> !ready_rise);
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !any_ev) |=> ready);

endmodule

bind settle_ready_timer settle_ready_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_ev(init_ev), .bufrst_ev(bufrst_ev),
  .rate_ev(rate_ev), .sync_ev(sync_ev), .scan_ev(scan_ev),
  .ready(ready), .ready_rise(ready_rise)
);

// File: tb/tb_settle_ready_timer.sv
module tb_settle_ready_timer;

  localparam int CLK_PERIOD = 10;
  localparam int INIT_CYC = 20;
  localparam int BF_CYC   = 3;
  localparam int BS_CYC   = 12;
  localparam int RATE_CYC = 40;
  localparam int SYNC_CYC = 15;
  localparam int SCAN_CYC = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_ev = 1'b0, bufrst_ev = 1'b0, rate_ev = 1'b0, sync_ev = 1'b0, scan_ev = 1'b0;
  logic sync_scan_mode = 1'b0;
  logic ready, ready_rise;

  always #(CLK_PERIOD/2) clk = ~clk;

  settle_ready_timer #(
    .INIT_CYC(INIT_CYC), .BRST_FAST_CYC(BF_CYC), .BRST_SCAN_CYC(BS_CYC),
    .RATE_CYC(RATE_CYC), .SYNC_CYC(SYNC_CYC), .SCAN_CYC(SCAN_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .init_ev(init_ev), .bufrst_ev(bufrst_ev),
    .rate_ev(rate_ev), .sync_ev(sync_ev), .scan_ev(scan_ev),
    .sync_scan_mode(sync_scan_mode), .ready(ready), .ready_rise(ready_rise)
  );

  typedef struct {
    bit    exp_ready;
    bit    exp_rise;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   rem    = INIT_CYC;
  bit   prev_ready = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", what, act, exp, $time);
    end
  endtask

  // Driver: one call per clock; computes the expected outputs after the next edge.
  task automatic step(input bit i, input bit b, input bit r, input bit s, input bit c,
                      input bit mode, input string tag);
    int req, dec, nrem;
    exp_t e;
    init_ev = i; bufrst_ev = b; rate_ev = r; sync_ev = s; scan_ev = c;
    sync_scan_mode = mode;
    req = 0;
    if (i && INIT_CYC > req) req = INIT_CYC;
    if (b && (mode ? BS_CYC : BF_CYC) > req) req = mode ? BS_CYC : BF_CYC;
    if (r && RATE_CYC > req) req = RATE_CYC;
    if (s && SYNC_CYC > req) req = SYNC_CYC;
    if (c && SCAN_CYC > req) req = SCAN_CYC;
    dec  = (rem > 0) ? rem - 1 : 0;
    nrem = (dec > req) ? dec : req;
    e.exp_ready = (nrem == 0);
    e.exp_rise  = (nrem == 0) && !prev_ready;
    e.tag = tag;
    prev_ready = e.exp_ready;
    rem = nrem;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, sync_scan_mode, tag);
  endtask

  // Monitor: compares one expected item per edge, away from the edge.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(ready, e.exp_ready, {e.tag, " ready"});
      check(ready_rise, e.exp_rise, {e.tag, " ready_rise"});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready, 1'b0, "R1 ready in reset");
    check(ready_rise, 1'b0, "R1 ready_rise in reset");
    rst_n = 1'b1;
    idle(INIT_CYC + 3, "R1/R10");
    idle(5, "R12");
    step(1, 0, 0, 0, 0, 0, "R2"); idle(INIT_CYC + 2, "R2");
    step(0, 1, 0, 0, 0, 0, "R3"); idle(BF_CYC + 2, "R3");
    step(0, 1, 0, 0, 0, 1, "R4"); idle(BS_CYC + 2, "R4");
    step(0, 0, 1, 0, 0, 0, "R5"); idle(RATE_CYC + 2, "R5");
    step(0, 0, 0, 1, 0, 0, "R6"); idle(SYNC_CYC + 2, "R6");
    step(0, 0, 0, 0, 1, 0, "R7"); idle(SCAN_CYC + 2, "R7");
    // R8: shorter event mid-interval must not shorten, later one extends
    step(0, 0, 1, 0, 0, 0, "R8"); idle(10, "R8");
    step(0, 0, 0, 1, 0, 0, "R8"); idle(20, "R8");
    step(0, 0, 0, 0, 1, 0, "R8"); idle(SCAN_CYC + 2, "R8");
    // R9: simultaneous strobes, longest wins
    step(0, 1, 1, 1, 0, 0, "R9"); idle(RATE_CYC + 2, "R9");
    step(0, 1, 0, 0, 1, 1, "R9"); idle(SCAN_CYC + 2, "R9");
    // R11: event exactly on the expiring edge
    step(0, 0, 0, 1, 0, 0, "R11"); idle(SYNC_CYC - 1, "R11");
    step(0, 1, 0, 0, 0, 0, "R11"); idle(BF_CYC + 2, "R11");
    idle(4, "R12");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule